// File: doc/BRIEF.md
# SPI Flash Sector Write Engine

This block writes whole logical sectors of a serial NOR flash through a mode-0 SPI master port. A start pulse carries a sector number and a size select. The engine polls the flash status until it is no longer busy, sends a write-enable frame, and erases the sector with the opcode that matches the selected size. It then takes a byte stream on a valid/ready input.

Page-program frames are not opened until the first data byte arrives. The engine opens one for each 256-byte page. Before each page it polls the status, sends a write-enable, and sends a program header. When a page is full it raises chip select, which commits that page. A next-sector pulse closes the open frame and erases the following sector. A finish pulse closes the frame and returns the engine to idle. Errors are reported as a one-cycle pulse that carries a 3-bit code.

Top module: `sfw_writer`

## Requirements
- R1: After reset, chip select is high, the serial clock is low, `data_ready_o` is low and `err_valid_o` is low.
- R2: SPI runs in mode 0. The serial clock idles low and is never high while chip select is high. Bytes are sent most significant bit first, with MOSI stable across the rising edge.
- R3: A start in idle produces three frames, each in its own chip-select frame: a status poll (opcode 0x05, then read bytes until bit 0 of a status byte is 0), a write-enable (0x06 alone), and an erase. The erase is opcode 0x20 with a 4 KiB sector (exponent 12) when `erase_big_i`=0, or 0xD8 with a 64 KiB sector (exponent 16) when it is 1. The erase carries a 3-byte address, most significant byte first, equal to the sector number shifted left by the exponent.
- R4: After the erase frame closes, `data_ready_o` rises. The first accepted byte causes a status poll frame, a write-enable frame, and then a frame that starts with 0x02, two page-number bytes (high byte first) and 0x00, followed by that data byte.
- R5: The first page number of a sector equals the sector number shifted left by (exponent − 8). Chip select rises right after the 256th byte of a page. The next byte opens a new program frame with the page number incremented by 1.
- R6: `data_ready_o` is low while a page setup, a status poll or a byte shift is in progress.
- R7: A next-sector pulse closes any open frame and then runs the R3 sequence for the stored sector number plus 1, with the same size select.
- R8: A finish pulse closes any open frame and returns the engine to idle, where `data_ready_o` stays low and no further frame is sent.
- R9: A start pulse while a program frame is open (chip select low) gives `err_valid_o` with code 4. It sends no frame and leaves the open frame undisturbed, so the next byte is sent with no new header.
- R10: If `POLL_MAX` consecutive status bytes all read busy, the engine raises chip select, reports code 2, and goes to idle. This applies to the poll before an erase and to the poll before a page.
- R11: Between two frames, chip select stays high for at least `GAP_CYC` clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin writing at `sector_i` |
| sector_i | input | SEC_W | Sector number for a start |
| erase_big_i | input | 1 | 1: 64 KiB sectors, 0: 4 KiB sectors |
| next_i | input | 1 | Continue with the following sector |
| finish_i | input | 1 | Close the frame and go idle |
| data_i | input | 8 | Data byte |
| data_valid_i | input | 1 | Data byte valid |
| data_ready_o | output | 1 | Engine accepts a data byte |
| err_valid_o | output | 1 | One-cycle error pulse |
| err_code_o | output | 3 | Error code (2 timeout, 4 pending) |
| spi_sclk_o | output | 1 | Serial clock |
| spi_cs_n_o | output | 1 | Chip select, active low |
| spi_mosi_o | output | 1 | Serial data to flash |
| spi_miso_i | input | 1 | Serial data from flash |

## Verification
The hardest situation to reach is a start pulse that arrives while a program frame is still open. Chip select is low only between two data bytes of a partly filled page. The bench therefore writes 258 bytes, which crosses a page boundary and leaves two bytes in a new page, and pulses start while the engine waits there. Timeouts depend on the flash staying busy. The behavioural flash model in the bench keeps bit 0 set for a programmable number of status bytes, which the bench raises above `POLL_MAX` before an erase and again before a page.

// File: rtl/sfw_pkg.sv
package sfw_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_STREAM, ST_GAP, ST_POLL_CMD, ST_POLL_RD, ST_WREN, ST_HDR, ST_DATA
    } sfw_state_e;

    localparam logic [7:0] CMD_STATUS    = 8'h05;
    localparam logic [7:0] CMD_WR_EN     = 8'h06;
    localparam logic [7:0] CMD_PROG      = 8'h02;
    localparam logic [7:0] CMD_ERASE_4K  = 8'h20;
    localparam logic [7:0] CMD_ERASE_64K = 8'hD8;
    localparam logic [7:0] BUSY_MASK     = 8'h01;

    localparam logic [2:0] ERR_TIMEOUT = 3'd2;
    localparam logic [2:0] ERR_PENDING = 3'd4;
endpackage

// File: rtl/sfw_shift.sv
module sfw_shift (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go_i,
    input  logic [7:0] tx_i,
    input  logic       miso_i,
    output logic       sclk_o,
    output logic       mosi_o,
    output logic       done_o,
    output logic [7:0] rx_o
);
    typedef struct packed {
        logic       active;
        logic       ph;
        logic [2:0] cnt;
        logic [7:0] tx;
        logic [7:0] rx;
        logic       done;
    } shf_t;

    shf_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        if (go_i && !r_q.active) begin
            r_d.active = 1'b1;
            r_d.ph     = 1'b0;
            r_d.cnt    = 3'd0;
            r_d.tx     = tx_i;
        end else if (r_q.active) begin
            if (!r_q.ph) begin
                r_d.ph = 1'b1;
            end else begin
                r_d.ph  = 1'b0;
                r_d.tx  = {r_q.tx[6:0], 1'b0};
                r_d.rx  = {r_q.rx[6:0], miso_i};
                r_d.cnt = r_q.cnt + 3'd1;
                if (r_q.cnt == 3'd7) begin
                    r_d.active = 1'b0;
                    r_d.done   = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign sclk_o = r_q.active & r_q.ph;
    assign mosi_o = r_q.active & r_q.tx[7];
    assign done_o = r_q.done;
    assign rx_o   = r_q.rx;

    // R2
    sclk_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_o |=> !sclk_o);
    // R2
    go_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go_i |-> !r_q.active);
endmodule

// File: rtl/sfw_page_base.sv
module sfw_page_base #(
    parameter int SEC_W     = 16,
    parameter int PAGE_W    = 16,
    parameter int SMALL_EXP = 12,
    parameter int BIG_EXP   = 16
) (
    input  logic [SEC_W-1:0]  sector_i,
    input  logic              big_i,
    output logic [PAGE_W-1:0] page_o,
    output logic [7:0]        erase_op_o
);
    import sfw_pkg::*;
    localparam int SMALL_SH = SMALL_EXP - 8;
    localparam int BIG_SH   = BIG_EXP - 8;

    logic [PAGE_W-1:0] wide;
    assign wide       = PAGE_W'(sector_i);
    assign page_o     = big_i ? (wide << BIG_SH) : (wide << SMALL_SH);
    assign erase_op_o = big_i ? CMD_ERASE_64K : CMD_ERASE_4K;
endmodule

// File: rtl/sfw_writer.sv
module sfw_writer #(
    parameter int SEC_W     = 16,
    parameter int PAGE_W    = 16,
    parameter int SMALL_EXP = 12,
    parameter int BIG_EXP   = 16,
    parameter int GAP_CYC   = 4,
    parameter int POLL_MAX  = 4096
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [SEC_W-1:0] sector_i,
    input  logic             erase_big_i,
    input  logic             next_i,
    input  logic             finish_i,
    input  logic [7:0]       data_i,
    input  logic             data_valid_i,
    output logic             data_ready_o,
    output logic             err_valid_o,
    output logic [2:0]       err_code_o,
    output logic             spi_sclk_o,
    output logic             spi_cs_n_o,
    output logic             spi_mosi_o,
    input  logic             spi_miso_i
);
    import sfw_pkg::*;
    localparam int GW = $clog2(GAP_CYC + 1);
    localparam int PW = $clog2(POLL_MAX + 1);

    typedef struct packed {
        sfw_state_e        state;
        sfw_state_e        ret;
        logic              pp;
        logic              need_pp;
        logic              cs_n;
        logic              go;
        logic [7:0]        tx;
        logic [SEC_W-1:0]  sector;
        logic              big;
        logic [PAGE_W-1:0] page;
        logic [7:0]        off;
        logic [1:0]        idx;
        logic [GW-1:0]     gap;
        logic [PW-1:0]     poll;
        logic [7:0]        hold;
        logic              err_v;
        logic [2:0]        err_c;
    } regs_t;

    regs_t r_d, r_q;

    logic              shf_done;
    logic [7:0]        shf_rx;
    logic [PAGE_W-1:0] base_page;
    logic [7:0]        erase_op;
    logic [23:0]       addr;
    logic [7:0]        addr_byte;
    logic              flash_busy;

    sfw_shift shf_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .go_i   (r_q.go),
        .tx_i   (r_q.tx),
        .miso_i (spi_miso_i),
        .sclk_o (spi_sclk_o),
        .mosi_o (spi_mosi_o),
        .done_o (shf_done),
        .rx_o   (shf_rx)
    );

    sfw_page_base #(
        .SEC_W(SEC_W), .PAGE_W(PAGE_W), .SMALL_EXP(SMALL_EXP), .BIG_EXP(BIG_EXP)
    ) base_i (
        .sector_i   (r_q.sector),
        .big_i      (r_q.big),
        .page_o     (base_page),
        .erase_op_o (erase_op)
    );

    assign flash_busy = (shf_rx & BUSY_MASK) != 8'h00;
    assign addr       = 24'({(r_q.pp ? r_q.page : base_page), 8'h00});

    always_comb begin
        case (r_q.idx)
            2'd0:    addr_byte = addr[23:16];
            2'd1:    addr_byte = addr[15:8];
            default: addr_byte = addr[7:0];
        endcase
    end

    always_comb begin
        r_d       = r_q;
        r_d.go    = 1'b0;
        r_d.err_v = 1'b0;
        case (r_q.state)
            ST_IDLE, ST_STREAM: begin
                if (start_i) begin
                    if (!r_q.cs_n) begin
                        r_d.err_v = 1'b1;
                        r_d.err_c = ERR_PENDING;
                    end else begin
                        r_d.sector  = sector_i;
                        r_d.big     = erase_big_i;
                        r_d.pp      = 1'b0;
                        r_d.need_pp = 1'b0;
                        r_d.state   = ST_GAP;
                        r_d.gap     = GW'(GAP_CYC - 1);
                        r_d.ret     = ST_POLL_CMD;
                    end
                end else if (r_q.state == ST_STREAM) begin
                    if (next_i) begin
                        r_d.cs_n    = 1'b1;
                        r_d.sector  = r_q.sector + SEC_W'(1);
                        r_d.pp      = 1'b0;
                        r_d.need_pp = 1'b0;
                        r_d.state   = ST_GAP;
                        r_d.gap     = GW'(GAP_CYC - 1);
                        r_d.ret     = ST_POLL_CMD;
                    end else if (finish_i) begin
                        r_d.cs_n    = 1'b1;
                        r_d.need_pp = 1'b0;
                        r_d.state   = ST_GAP;
                        r_d.gap     = GW'(GAP_CYC - 1);
                        r_d.ret     = ST_IDLE;
                    end else if (data_valid_i) begin
                        if (r_q.need_pp) begin
                            r_d.hold    = data_i;
                            r_d.pp      = 1'b1;
                            r_d.need_pp = 1'b0;
                            r_d.cs_n    = 1'b0;
                            r_d.go      = 1'b1;
                            r_d.tx      = CMD_STATUS;
                            r_d.poll    = '0;
                            r_d.state   = ST_POLL_CMD;
                        end else begin
                            r_d.go    = 1'b1;
                            r_d.tx    = data_i;
                            r_d.state = ST_DATA;
                        end
                    end
                end
            end
            ST_GAP: begin
                if (r_q.gap == '0) begin
                    r_d.state = r_q.ret;
                    case (r_q.ret)
                        ST_POLL_CMD: begin
                            r_d.cs_n = 1'b0; r_d.go = 1'b1;
                            r_d.tx = CMD_STATUS; r_d.poll = '0;
                        end
                        ST_WREN: begin
                            r_d.cs_n = 1'b0; r_d.go = 1'b1; r_d.tx = CMD_WR_EN;
                        end
                        ST_HDR: begin
                            r_d.cs_n = 1'b0; r_d.go = 1'b1; r_d.idx = 2'd0;
                            r_d.tx = r_q.pp ? CMD_PROG : erase_op;
                        end
                        default: ;
                    endcase
                end else begin
                    r_d.gap = r_q.gap - GW'(1);
                end
            end
            ST_POLL_CMD: if (shf_done) begin
                r_d.go = 1'b1; r_d.tx = 8'h00; r_d.state = ST_POLL_RD;
            end
            ST_POLL_RD: if (shf_done) begin
                if (!flash_busy) begin
                    r_d.cs_n = 1'b1; r_d.state = ST_GAP;
                    r_d.gap = GW'(GAP_CYC - 1); r_d.ret = ST_WREN;
                end else if (r_q.poll == PW'(POLL_MAX - 1)) begin
                    r_d.cs_n = 1'b1; r_d.need_pp = 1'b0;
                    r_d.err_v = 1'b1; r_d.err_c = ERR_TIMEOUT;
                    r_d.state = ST_GAP; r_d.gap = GW'(GAP_CYC - 1); r_d.ret = ST_IDLE;
                end else begin
                    r_d.poll = r_q.poll + PW'(1);
                    r_d.go = 1'b1; r_d.tx = 8'h00;
                end
            end
            ST_WREN: if (shf_done) begin
                r_d.cs_n = 1'b1; r_d.state = ST_GAP;
                r_d.gap = GW'(GAP_CYC - 1); r_d.ret = ST_HDR;
            end
            ST_HDR: if (shf_done) begin
                if (r_q.idx == 2'd3) begin
                    if (r_q.pp) begin
                        r_d.go = 1'b1; r_d.tx = r_q.hold; r_d.state = ST_DATA;
                    end else begin
                        r_d.cs_n = 1'b1; r_d.page = base_page; r_d.off = 8'h00;
                        r_d.need_pp = 1'b1; r_d.state = ST_GAP;
                        r_d.gap = GW'(GAP_CYC - 1); r_d.ret = ST_STREAM;
                    end
                end else begin
                    r_d.idx = r_q.idx + 2'd1;
                    r_d.go  = 1'b1;
                    r_d.tx  = addr_byte;
                end
            end
            ST_DATA: if (shf_done) begin
                r_d.off = r_q.off + 8'd1;
                if (r_q.off == 8'hFF) begin
                    r_d.page = r_q.page + PAGE_W'(1);
                    r_d.need_pp = 1'b1; r_d.cs_n = 1'b1; r_d.state = ST_GAP;
                    r_d.gap = GW'(GAP_CYC - 1); r_d.ret = ST_STREAM;
                end else begin
                    r_d.state = ST_STREAM;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.cs_n <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign data_ready_o = (r_q.state == ST_STREAM) && !start_i && !next_i && !finish_i;
    assign err_valid_o  = r_q.err_v;
    assign err_code_o   = r_q.err_c;
    assign spi_cs_n_o   = r_q.cs_n;

    logic [7:0] hi_cnt_q;
    always_ff @(posedge clk) begin
        if (!rst_n)                           hi_cnt_q <= '0;
        else if (!spi_cs_n_o)                 hi_cnt_q <= '0;
        else if (hi_cnt_q != 8'hFF)           hi_cnt_q <= hi_cnt_q + 8'd1;
    end

    // R11
    cs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(spi_cs_n_o) |-> hi_cnt_q >= 8'(GAP_CYC));
    // R2
    sclk_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n_o |-> !spi_sclk_o);
    // R6
    ready_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_ready_o |-> !spi_sclk_o);
    // R9
    pend_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_valid_o && err_code_o == ERR_PENDING) |-> !spi_cs_n_o);
    // R10
    tout_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_valid_o && err_code_o == ERR_TIMEOUT) |-> spi_cs_n_o);
endmodule

// File: tb/sfw_writer_tb_top.sv
module sfw_writer_tb_top;
    localparam int GAP = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic        start_i = 0, erase_big_i = 0, next_i = 0, finish_i = 0;
    logic [15:0] sector_i = '0;
    logic [7:0]  data_i = '0;
    logic        data_valid_i = 0;
    logic        data_ready_o, err_valid_o;
    logic [2:0]  err_code_o;
    logic        spi_sclk_o, spi_cs_n_o, spi_mosi_o;
    logic        spi_miso_i = 1'b0;

    sfw_writer #(.GAP_CYC(GAP), .POLL_MAX(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .sector_i(sector_i),
        .erase_big_i(erase_big_i), .next_i(next_i), .finish_i(finish_i),
        .data_i(data_i), .data_valid_i(data_valid_i), .data_ready_o(data_ready_o),
        .err_valid_o(err_valid_o), .err_code_o(err_code_o),
        .spi_sclk_o(spi_sclk_o), .spi_cs_n_o(spi_cs_n_o),
        .spi_mosi_o(spi_mosi_o), .spi_miso_i(spi_miso_i)
    );

    int    checks = 0, fails = 0, busy_cnt = 0;
    int    exp_q[$];
    string tag_q[$];

    function automatic void note(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endfunction

    // scoreboard compare: 0x100 marks a chip-select rise
    function automatic void sb_check(int v);
        int    e;
        string t;
        if (exp_q.size() == 0) begin
            note(0, "R2", "unexpected spi event", v, -1);
        end else begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            note(e == v, t, "spi event", v, e);
        end
    endfunction

    function automatic void push(int v, string t);
        exp_q.push_back(v);
        tag_q.push_back(t);
    endfunction
    function automatic void exp_poll(string t);
        push(8'h05, t); push(9'h100, t);
    endfunction
    function automatic void exp_wren(string t);
        push(8'h06, t); push(9'h100, t);
    endfunction
    function automatic void exp_erase(int op, int a24, string t);
        push(op, t); push((a24 >> 16) & 255, t); push((a24 >> 8) & 255, t);
        push(a24 & 255, t); push(9'h100, t);
    endfunction
    function automatic void exp_pp(int pg, string t);
        push(8'h02, t); push((pg >> 8) & 255, t); push(pg & 255, t); push(0, t);
    endfunction

    // flash model and frame monitor
    logic [7:0] m_sh = '0;
    logic [7:0] m_opc = '0;
    int         m_bits = 0;

    always @(posedge spi_sclk_o) if (!spi_cs_n_o) begin
        m_sh = {m_sh[6:0], spi_mosi_o};
        m_bits++;
        if (m_bits % 8 == 0) begin
            if (m_bits == 8) m_opc = m_sh;
            if (m_bits == 8 || m_opc != 8'h05) sb_check(int'(m_sh));
            if (m_opc == 8'h05 && m_bits > 8 && busy_cnt > 0) busy_cnt--;
        end
    end

    always @(posedge spi_cs_n_o) begin
        if (m_bits > 0) sb_check(9'h100);
        m_bits = 0;
    end

    always @(negedge spi_sclk_o or negedge spi_cs_n_o)
        spi_miso_i <= (m_opc == 8'h05 && m_bits >= 8 && m_bits % 8 == 7 && busy_cnt > 0);

    // R11 gap and R2 idle clock, sampled away from the active edge
    int hi_b = 0;
    logic was_hi = 1'b0;
    always @(negedge clk) if (rst_n) begin
        if (spi_cs_n_o && spi_sclk_o) note(0, "R2", "sclk high while deselected", 1, 0);
        if (spi_cs_n_o) hi_b++;
        else begin
            if (was_hi) note(hi_b >= GAP, "R11", "cs high cycles", hi_b, GAP);
            hi_b = 0;
        end
        was_hi = spi_cs_n_o;
    end

    task automatic wait_ready();
        do @(negedge clk); while (!data_ready_o);
    endtask

    task automatic send_byte(logic [7:0] b, string t, bit expect_it);
        if (expect_it) push(int'(b), t);
        wait_ready();
        data_valid_i = 1'b1;
        data_i = b;
        @(negedge clk);
        data_valid_i = 1'b0;
    endtask

    task automatic do_start(int sec, bit big);
        @(negedge clk);
        start_i = 1'b1; sector_i = 16'(sec); erase_big_i = big;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_err(output bit got);
        got = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (err_valid_o) begin got = 1'b1; break; end
        end
    endtask

    task automatic settle();
        repeat (GAP + 40) @(negedge clk);
    endtask

    initial begin
        repeat (2000000) @(posedge clk);
        note(0, "R1", "watchdog expired", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        bit got;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        note(spi_cs_n_o == 1'b1, "R1", "cs_n after reset", spi_cs_n_o, 1);
        note(spi_sclk_o == 1'b0, "R1", "sclk after reset", spi_sclk_o, 0);
        note(data_ready_o == 1'b0, "R1", "ready after reset", data_ready_o, 0);
        note(err_valid_o == 1'b0, "R1", "err after reset", err_valid_o, 0);

        // R3 small-sector start, sector 3 -> erase 0x20 at 0x003000
        busy_cnt = 2;
        exp_poll("R3"); exp_wren("R3"); exp_erase(8'h20, 24'h003000, "R3");
        do_start(3, 1'b0);
        wait_ready();
        note(data_ready_o == 1'b1, "R4", "ready after erase", data_ready_o, 1);

        // R4 R5 258 bytes across the boundary of page 0x30
        for (int i = 0; i < 258; i++) begin
            if (i == 0) begin
                busy_cnt = 1;
                exp_poll("R4"); exp_wren("R4"); exp_pp(16'h0030, "R4");
            end
            if (i == 256) begin
                exp_poll("R5"); exp_wren("R5"); exp_pp(16'h0031, "R5");
            end
            send_byte(8'((i * 7 + 1) & 255), "R5", 1'b1);
            if (i == 0 || i == 256)
                note(data_ready_o == 1'b0, "R6", "ready during page setup", data_ready_o, 0);
            if (i == 5)
                note(data_ready_o == 1'b0, "R6", "ready during shift", data_ready_o, 0);
            if (i == 255) push(9'h100, "R5");
        end

        // R9 start while the page frame is open
        wait_ready();
        do_start(9, 1'b0);
        note(err_valid_o == 1'b1, "R9", "pending error pulse", err_valid_o, 1);
        note(err_code_o == 3'd4, "R9", "pending error code", err_code_o, 4);
        note(spi_cs_n_o == 1'b0, "R9", "frame stays open", spi_cs_n_o, 0);
        send_byte(8'hA5, "R9", 1'b1);

        // R7 next sector: 4 -> erase 0x004000, page 0x40
        busy_cnt = 1;
        push(9'h100, "R7");
        exp_poll("R7"); exp_wren("R7"); exp_erase(8'h20, 24'h004000, "R7");
        wait_ready();
        @(negedge clk); next_i = 1'b1; @(negedge clk); next_i = 1'b0;
        wait_ready();
        note(data_ready_o == 1'b1, "R7", "ready after next erase", data_ready_o, 1);
        exp_poll("R7"); exp_wren("R7"); exp_pp(16'h0040, "R7");
        send_byte(8'h5A, "R7", 1'b1);

        // R8 finish
        push(9'h100, "R8");
        wait_ready();
        @(negedge clk); finish_i = 1'b1; @(negedge clk); finish_i = 1'b0;
        settle();
        note(data_ready_o == 1'b0, "R8", "ready after finish", data_ready_o, 0);
        note(spi_cs_n_o == 1'b1, "R8", "cs_n after finish", spi_cs_n_o, 1);
        note(exp_q.size() == 0, "R8", "pending expected events", exp_q.size(), 0);

        // R3 R5 big sector 2 -> erase 0xD8 at 0x020000, page 0x0200
        exp_poll("R3"); exp_wren("R3"); exp_erase(8'hD8, 24'h020000, "R3");
        do_start(2, 1'b1);
        wait_ready();
        exp_poll("R5"); exp_wren("R5"); exp_pp(16'h0200, "R5");
        send_byte(8'h3C, "R5", 1'b1);
        push(9'h100, "R8");
        wait_ready();
        @(negedge clk); finish_i = 1'b1; @(negedge clk); finish_i = 1'b0;
        settle();
        note(exp_q.size() == 0, "R3", "pending expected events", exp_q.size(), 0);

        // R10 timeout before an erase
        busy_cnt = 50;
        exp_poll("R10");
        do_start(1, 1'b0);
        wait_err(got);
        note(got, "R10", "timeout pulse before erase", got, 1);
        note(err_code_o == 3'd2, "R10", "timeout code", err_code_o, 2);
        settle();
        note(data_ready_o == 1'b0, "R10", "ready after timeout", data_ready_o, 0);
        note(spi_cs_n_o == 1'b1, "R10", "cs_n after timeout", spi_cs_n_o, 1);
        busy_cnt = 0;

        // R10 timeout before a page
        exp_poll("R3"); exp_wren("R3"); exp_erase(8'h20, 24'h001000, "R3");
        do_start(1, 1'b0);
        wait_ready();
        busy_cnt = 50;
        exp_poll("R10");
        send_byte(8'h77, "R10", 1'b0);
        wait_err(got);
        note(got, "R10", "timeout pulse before page", got, 1);
        note(err_code_o == 3'd2, "R10", "timeout code page", err_code_o, 2);
        settle();
        note(data_ready_o == 1'b0, "R10", "ready after page timeout", data_ready_o, 0);
        note(exp_q.size() == 0, "R10", "pending expected events", exp_q.size(), 0);
        busy_cnt = 0;

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule